// File: doc/BRIEF.md
# Receive Page Ring Manager

This block places incoming frames into a circular area of local memory built from fixed 256-byte pages. Two configuration inputs bound the ring: the first page that belongs to it, and the page just beyond its last page. The block keeps the current page, which is where the next frame will be stored, and the boundary page, which marks how far the host has consumed stored frames. Only the host moves the boundary, by writing it.

An upstream receiver marks the start of each frame, hands over payload bytes one at a time, and then reports the end of the frame together with a good/bad verdict and a status byte. Payload is written from offset 4 of the current page onward. When a page fills, the write pointer moves to the following page, and from the last page of the ring it wraps back to the first. A good frame gets a 4-byte header at offset 0 of its first page: status, link to the next free page, and the total byte count. The current page then moves past the frame. A bad frame leaves the current page where it was, so its pages are used again. If the write pointer would step onto the boundary page, storage stops and a sticky overflow flag is raised. A host write to the boundary clears that flag.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, curPage and bndPage are 0, ovfFlag, busy, memWe and pktDone are 0.
- R2: A ringInit pulse while idle loads curPage from pageStart on the next clock.
- R3: When a page advance would make the write page equal bndPage, either when offset 255 is written or at a good end whose last byte is not at offset 255, ovfFlag is set. The frame is dropped with no header and curPage unchanged, and while ovfFlag is 1 pktStart is ignored and memWe stays 0.
- R4: Payload byte k of a frame (k from 0) is written, in the cycle rxValid is high, at page curPage plus floor((k+4)/256) in ring order, offset (k+4) mod 256; memAddr is {page, offset}.
- R5: The page after pageStop-1 is pageStart; every other page is followed by page+1.
- R6: After a good pktEnd, the header is written in the next four cycles at offsets 0,1,2,3 of the frame's first page, holding status, next page, count low byte and count high byte; pktDone pulses for one cycle in the cycle after the last header write.
- R7: The byte count in the header equals the payload byte count plus 4 and is stored low byte first.
- R8: The next page is the page after the one holding the last written byte, in ring order; curPage takes that value in the cycle pktDone is high.
- R9: A pktEnd with pktGood=0 writes no header and leaves curPage unchanged.
- R10: bndWrEn loads bndPage from bndWrData on the next clock and clears ovfFlag unless an overflow is set in the same cycle.
- R11: rxValid while no frame is open causes no write, and pktStart while a frame is open or its header is being written has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pageStart | input | PAGE_W | First page of the ring |
| pageStop | input | PAGE_W | Page just past the last page of the ring |
| ringInit | input | 1 | Load current page from pageStart |
| bndWrEn | input | 1 | Host boundary write strobe |
| bndWrData | input | PAGE_W | New boundary page |
| pktStart | input | 1 | Frame begins |
| rxValid | input | 1 | Payload byte valid |
| rxData | input | 8 | Payload byte |
| pktEnd | input | 1 | Frame ends |
| pktGood | input | 1 | Frame verdict, sampled with pktEnd |
| rxStatus | input | 8 | Status byte, sampled with pktEnd |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | PAGE_W+OFF_W | Memory byte address {page, offset} |
| memData | output | 8 | Memory write data |
| curPage | output | PAGE_W | Current page |
| bndPage | output | PAGE_W | Boundary page |
| ovfFlag | output | 1 | Sticky overflow flag |
| busy | output | 1 | Frame open or header being written |
| pktDone | output | 1 | One-cycle pulse after a frame is stored |

## Verification
Every cycle, the assertions check that no write happens while the overflow flag is up, that writes stay inside the configured page range, that the current page moves only on an init or a commit, that the overflow flag falls only after a boundary write, and that the done pulse comes right after a header write. The header contents, the exact next-page link across the wrap, the handling of a frame that ends exactly on a page edge, and both ways an overflow can happen are only shown by the bench's frame sequences, compared cycle by cycle against its reference model and against fixed expected values.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int HDR_LEN = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HDR  = 2'd2
  } ringState_t;

  typedef struct packed {
    logic       init;
    logic       start;
    logic       wrByte;
    logic       finish;
    logic       hdrWr;
    logic       commit;
    logic       setOvf;
    logic [1:0] hdrSel;
  } ringStrb_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ringInit,
  input  logic      pktStart,
  input  logic      rxValid,
  input  logic      pktEnd,
  input  logic      pktGood,
  input  logic      ovfFlag,
  input  logic      advHit,
  input  logic      endHit,
  output ringStrb_t strb,
  output logic      busy,
  output logic      pktDone
);
  localparam logic [1:0] LAST_HDR = 2'(HDR_LEN - 1);

  ringState_t state, stateNxt;
  logic [1:0] hdrSel;
  logic       doneQ;

  always_comb begin
    strb        = '0;
    strb.hdrSel = hdrSel;
    stateNxt    = state;
    unique case (state)
      ST_IDLE: begin
        if (ringInit) begin
          strb.init = 1'b1;
        end else if (pktStart && !ovfFlag) begin
          strb.start = 1'b1;
          stateNxt   = ST_RECV;
        end
      end
      ST_RECV: begin
        if (pktEnd) begin
          if (!pktGood) begin
            stateNxt = ST_IDLE;
          end else if (endHit) begin
            strb.setOvf = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            strb.finish = 1'b1;
            stateNxt    = ST_HDR;
          end
        end else if (rxValid) begin
          strb.wrByte = 1'b1;
          if (advHit) begin
            strb.setOvf = 1'b1;
            stateNxt    = ST_IDLE;
          end
        end
      end
      ST_HDR: begin
        strb.hdrWr = 1'b1;
        if (hdrSel == LAST_HDR) begin
          strb.commit = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hdrSel <= '0;
      doneQ  <= 1'b0;
    end else begin
      state  <= stateNxt;
      hdrSel <= (state == ST_HDR) ? hdrSel + 2'd1 : 2'd0;
      doneQ  <= strb.commit;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign pktDone = doneQ;

  // R6: the done pulse follows the last header write
  p_done_after_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pktDone |-> $past(strb.hdrWr));
endmodule

// File: rtl/rx_ring_dpath.sv
module rx_ring_dpath
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ringStrb_t         strb,
  input  logic [PAGE_W-1:0] pageStart,
  input  logic [PAGE_W-1:0] pageStop,
  input  logic              bndWrEn,
  input  logic [PAGE_W-1:0] bndWrData,
  input  logic [7:0]        rxData,
  input  logic [7:0]        rxStatus,
  output logic              advHit,
  output logic              endHit,
  output logic [PAGE_W-1:0] curPage,
  output logic [PAGE_W-1:0] bndPage,
  output logic              ovfFlag,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  logic [PAGE_W-1:0] wrPage, nextReg, advPage, endPage;
  logic [OFF_W-1:0]  wrOff, hdrOff;
  logic [CNT_W-1:0]  byteCnt;
  logic [7:0]        statusReg;

  function automatic logic [PAGE_W-1:0] ringNext(input logic [PAGE_W-1:0] pg);
    logic [PAGE_W:0] sum;
    sum = {1'b0, pg} + 1'b1;
    if (sum == {1'b0, pageStop}) return pageStart;
    return sum[PAGE_W-1:0];
  endfunction

  assign advPage = ringNext(wrPage);
  assign endPage = (wrOff == '0) ? wrPage : advPage;
  assign advHit  = (&wrOff) && (advPage == bndPage);
  assign endHit  = (wrOff != '0) && (advPage == bndPage);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curPage   <= '0;
      bndPage   <= '0;
      ovfFlag   <= 1'b0;
      wrPage    <= '0;
      wrOff     <= '0;
      byteCnt   <= '0;
      nextReg   <= '0;
      statusReg <= '0;
    end else begin
      if (strb.init)   curPage <= pageStart;
      if (strb.commit) curPage <= nextReg;
      if (strb.start) begin
        wrPage  <= curPage;
        wrOff   <= OFF_W'(HDR_LEN);
        byteCnt <= CNT_W'(HDR_LEN);
      end
      if (strb.wrByte) begin
        wrOff   <= wrOff + 1'b1;
        byteCnt <= byteCnt + 1'b1;
        if (&wrOff) wrPage <= advPage;
      end
      if (strb.finish) begin
        nextReg   <= endPage;
        statusReg <= rxStatus;
      end
      if (bndWrEn) bndPage <= bndWrData;
      if (strb.setOvf)  ovfFlag <= 1'b1;
      else if (bndWrEn) ovfFlag <= 1'b0;
    end
  end

  assign hdrOff = {{(OFF_W-2){1'b0}}, strb.hdrSel};
  assign memWe  = strb.wrByte | strb.hdrWr;

  always_comb begin
    if (strb.hdrWr) begin
      memAddr = {curPage, hdrOff};
      unique case (strb.hdrSel)
        2'd0:    memData = statusReg;
        2'd1:    memData = 8'(nextReg);
        2'd2:    memData = byteCnt[7:0];
        default: memData = 8'(byteCnt >> 8);
      endcase
    end else begin
      memAddr = {wrPage, wrOff};
      memData = rxData;
    end
  end

  // R8: the current page only moves on an init or a commit
  p_cur_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curPage) |-> $past(strb.commit || strb.init));

  // R10: overflow clears only through a boundary write
  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovfFlag) |-> $past(bndWrEn));
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] pageStart,
  input  logic [PAGE_W-1:0] pageStop,
  input  logic              ringInit,
  input  logic              bndWrEn,
  input  logic [PAGE_W-1:0] bndWrData,
  input  logic              pktStart,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              pktEnd,
  input  logic              pktGood,
  input  logic [7:0]        rxStatus,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] curPage,
  output logic [PAGE_W-1:0] bndPage,
  output logic              ovfFlag,
  output logic              busy,
  output logic              pktDone
);
  ringStrb_t strb;
  logic      advHit, endHit;

  rx_ring_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .ringInit(ringInit), .pktStart(pktStart),
    .rxValid(rxValid), .pktEnd(pktEnd), .pktGood(pktGood), .ovfFlag(ovfFlag),
    .advHit(advHit), .endHit(endHit), .strb(strb), .busy(busy), .pktDone(pktDone)
  );

  rx_ring_dpath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pageStart(pageStart),
    .pageStop(pageStop), .bndWrEn(bndWrEn), .bndWrData(bndWrData),
    .rxData(rxData), .rxStatus(rxStatus), .advHit(advHit), .endHit(endHit),
    .curPage(curPage), .bndPage(bndPage), .ovfFlag(ovfFlag), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );

  // R3: no memory write while the ring is halted
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovfFlag |-> !memWe);

  // R5: with a sane ring, every write lands inside it
  p_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && (pageStart < pageStop) && (curPage >= pageStart) && (curPage < pageStop))
    |-> (memAddr[ADDR_W-1:OFF_W] >= pageStart && memAddr[ADDR_W-1:OFF_W] < pageStop));
endmodule

// File: tb/rx_ring_mgr_tb.sv
module rx_ring_mgr_tb_top;
  localparam int START = 'h40;
  localparam int STOP  = 'h46;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pageStart = 8'(START), pageStop = 8'(STOP);
  logic ringInit = 0, bndWrEn = 0, pktStart = 0, rxValid = 0, pktEnd = 0, pktGood = 0;
  logic [7:0] bndWrData = 0, rxData = 0, rxStatus = 0;
  logic memWe, ovfFlag, busy, pktDone;
  logic [15:0] memAddr;
  logic [7:0] memData, curPage, bndPage;

  int total = 0, bad = 0, wrCount = 0;
  logic [7:0] shadow [int];

  // reference model state
  int mSt = 0, mCur = 0, mBnd = 0, mOvf = 0, mWrP = 0, mWrO = 0;
  int mCnt = 0, mNext = 0, mStat = 0, mIdx = 0, mDone = 0;

  always #10 clk = ~clk;

  rx_ring_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .pageStart(pageStart), .pageStop(pageStop),
    .ringInit(ringInit), .bndWrEn(bndWrEn), .bndWrData(bndWrData),
    .pktStart(pktStart), .rxValid(rxValid), .rxData(rxData), .pktEnd(pktEnd),
    .pktGood(pktGood), .rxStatus(rxStatus), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .curPage(curPage), .bndPage(bndPage), .ovfFlag(ovfFlag),
    .busy(busy), .pktDone(pktDone)
  );

  function automatic int wrapInc(int p);
    return (p + 1 == STOP) ? START : p + 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int setO, ep, np;
    if (!rst_n) begin
      mSt = 0; mCur = 0; mBnd = 0; mOvf = 0; mWrP = 0; mWrO = 0;
      mCnt = 0; mNext = 0; mStat = 0; mIdx = 0; mDone = 0;
    end else begin
      setO = 0;
      mDone = 0;
      case (mSt)
        0: if (ringInit) mCur = START;
           else if (pktStart && mOvf == 0) begin mSt = 1; mWrP = mCur; mWrO = 4; mCnt = 4; end
        1: if (pktEnd) begin
             if (!pktGood) mSt = 0;
             else begin
               ep = (mWrO == 0) ? mWrP : wrapInc(mWrP);
               if (mWrO != 0 && ep == mBnd) begin setO = 1; mSt = 0; end
               else begin mNext = ep; mStat = rxStatus; mSt = 2; mIdx = 0; end
             end
           end else if (rxValid) begin
             mCnt++;
             if (mWrO == 255) begin
               np = wrapInc(mWrP);
               if (np == mBnd) begin setO = 1; mSt = 0; end
               mWrP = np; mWrO = 0;
             end else mWrO++;
           end
        default: if (mIdx == 3) begin mCur = mNext; mSt = 0; mDone = 1; mIdx = 0; end
                 else mIdx++;
      endcase
      if (setO != 0) mOvf = 1;
      else if (bndWrEn) mOvf = 0;
      if (bndWrEn) mBnd = bndWrData;
    end
  end

  always @(negedge clk) begin
    int eWe, eAddr, eData;
    if (rst_n) begin
      eWe = ((mSt == 1 && rxValid && !pktEnd) || mSt == 2) ? 1 : 0;
      eAddr = (mSt == 2) ? mCur * 256 + mIdx : mWrP * 256 + mWrO;
      case (mIdx)
        0: eData = mStat;
        1: eData = mNext;
        2: eData = mCnt & 255;
        default: eData = (mCnt >> 8) & 255;
      endcase
      if (mSt != 2) eData = rxData;
      check(int'(memWe) == eWe, (mSt == 2) ? "R6 memWe" : "R11/R4 memWe", int'(memWe), eWe);
      if (eWe != 0) begin
        check(int'(memAddr) == eAddr, (mSt == 2) ? "R6 addr" : "R4/R5 addr", int'(memAddr), eAddr);
        check(int'(memData) == eData, (mSt == 2) ? "R7 data" : "R4 data", int'(memData), eData);
      end
      check(int'(curPage) == mCur, "R8 curPage", int'(curPage), mCur);
      check(int'(bndPage) == mBnd, "R10 bndPage", int'(bndPage), mBnd);
      check(int'(ovfFlag) == mOvf, "R3 ovfFlag", int'(ovfFlag), mOvf);
      check(int'(busy) == (mSt != 0 ? 1 : 0), "R11 busy", int'(busy), mSt != 0 ? 1 : 0);
      check(int'(pktDone) == mDone, "R6 pktDone", int'(pktDone), mDone);
      if (memWe) begin
        shadow[int'(memAddr)] = memData;
        wrCount++;
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sendPkt(int len, bit good, logic [7:0] st, bit extraStart = 0);
    pktStart = 1; tick(); pktStart = 0;
    for (int i = 0; i < len; i++) begin
      rxValid = 1; rxData = 8'(i) ^ 8'h5A;
      if (extraStart && i == 3) pktStart = 1;
      tick();
      pktStart = 0;
    end
    rxValid = 0;
    pktEnd = 1; pktGood = good; rxStatus = st; tick();
    pktEnd = 0; pktGood = 0;
    tick(6);
  endtask

  task automatic writeBnd(int v);
    bndWrEn = 1; bndWrData = 8'(v); tick(); bndWrEn = 0; tick();
  endtask

  function automatic int peek(int page, int off);
    int a;
    a = page * 256 + off;
    return shadow.exists(a) ? int'(shadow[a]) : -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    tick(3);
    // R1 reset state
    check(curPage == 0 && bndPage == 0, "R1 pointers", int'(curPage), 0);
    check(!ovfFlag && !busy && !memWe && !pktDone, "R1 flags", int'({ovfFlag, busy, memWe, pktDone}), 0);
    rst_n = 1; tick();
    ringInit = 1; tick(); ringInit = 0; tick();
    check(curPage == 8'(START), "R2 init", int'(curPage), START);
    writeBnd(START);
    // R11 idle bytes ignored
    w0 = wrCount;
    rxValid = 1; rxData = 8'hEE; tick(4); rxValid = 0; tick();
    check(wrCount == w0, "R11 idle write", wrCount, w0);
    // small good frame
    sendPkt(10, 1, 8'h21);
    check(curPage == 8'h41, "R8 small next", int'(curPage), 'h41);
    check(peek(START, 0) == 'h21, "R6 status byte", peek(START, 0), 'h21);
    check(peek(START, 2) == 14 && peek(START, 3) == 0, "R7 count", peek(START, 2), 14);
    check(peek(START, 4) == 'h5A, "R4 first payload", peek(START, 4), 'h5A);
    // rejected frame, also a stray pktStart mid-frame
    sendPkt(300, 0, 8'h00, 1);
    check(curPage == 8'h41, "R9 reject", int'(curPage), 'h41);
    check(peek('h41, 1) == -1, "R9 no header", peek('h41, 1), -1);
    // three-page frame
    sendPkt(600, 1, 8'h01);
    check(curPage == 8'h44, "R8 multi page", int'(curPage), 'h44);
    check(peek('h41, 1) == 'h44 && peek('h41, 3) == 2 && peek('h41, 2) == 'h5C, "R7 count 604", peek('h41, 2), 'h5C);
    // frame ends exactly on page edge
    sendPkt(252, 1, 8'h01);
    check(curPage == 8'h45, "R8 page edge", int'(curPage), 'h45);
    check(peek('h44, 3) == 1 && peek('h44, 2) == 0, "R7 count 256", peek('h44, 3), 1);
    // wrap onto the boundary page
    sendPkt(300, 1, 8'h01);
    check(ovfFlag == 1, "R3 overflow on advance", int'(ovfFlag), 1);
    check(curPage == 8'h45, "R3 cur kept", int'(curPage), 'h45);
    w0 = wrCount;
    sendPkt(5, 1, 8'h01);
    check(wrCount == w0, "R3 halted", wrCount, w0);
    writeBnd('h43);
    check(ovfFlag == 0 && bndPage == 8'h43, "R10 boundary write", int'(bndPage), 'h43);
    // wrap through the ring end
    sendPkt(300, 1, 8'h07);
    check(curPage == 8'h41, "R5 wrap next", int'(curPage), 'h41);
    check(peek('h45, 1) == 'h41 && peek(START, 0) == 'h5A ^ 252, "R5 wrapped payload", peek(START, 0), 'h5A ^ 252);
    check(peek('h45, 2) == 'h30 && peek('h45, 3) == 1, "R7 count 304", peek('h45, 2), 'h30);
    // overflow detected at frame end
    sendPkt(300, 1, 8'h01);
    check(ovfFlag == 1 && curPage == 8'h41, "R3 overflow at end", int'(curPage), 'h41);
    check(peek('h41, 0) == 'h01, "R3 no header on drop", peek('h41, 0), 'h01);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule